// File: doc/BRIEF.md
# Isochronous OUT endpoint receive controller

This block is the receive side of a double-buffered isochronous OUT endpoint in a USB device. A packet engine upstream delivers each OUT packet as a start pulse, a run of data bytes and an end pulse that carries a good/bad flag, because the CRC has already been checked. The controller writes each packet into one of two packet buffers. A good packet becomes readable, a bad packet is thrown away, and a packet that arrives while no buffer is free is dropped whole and recorded in a sticky overflow flag.

A host CPU drains the bytes one at a time through a read strobe, starting with the oldest complete packet. It watches an 8-bit control/status word through a plain register write strobe. The status bits are FIFO-service, packet-complete, overflow, DMA-mode, not-empty and short-packet. Two of the flags are cleared by writing one to them. A level receive interrupt combines the overflow flag with the packet-complete event. In DMA mode the packet-complete part waits until fewer than 32 bytes are left unread.

Top module: `iso_out_rx`

## Requirements
- R1: After reset, status bits 7:0 read 0, `rx_irq` is low and `rd_data` is 0.
- R2: Status bits 31:8 and 5:4 always read 0.
- R3: A good packet of 0 to 256 bytes is stored whole. `rd_data` shows the current byte of the oldest complete packet, and bytes come out in arrival order. When no byte is readable, `rd_data` is 0.
- R4: Bit 0 (service) is 1 exactly while at least one good complete packet is held. It falls only when every byte of both buffers has been read and any zero-length packet has been released.
- R5: Bit 6 (not-empty) is 1 exactly while at least one unread byte of a complete packet is held.
- R6: Bit 7 (short) is 1 while a complete packet is current and its length is below 256 bytes.
- R7: A start pulse that finds both buffers occupied (held or being filled) drops that whole packet and sets bit 2 (overflow). Stored packets and their contents are unchanged.
- R8: Writing 1 to bit 1 or bit 2 clears that bit. Writing 0 leaves it unchanged. If a set event and a clearing write fall in the same cycle, the bit stays 1.
- R9: Bit 1 (packet-complete) sets at the end of every accepted packet, good or bad. Dropped packets do not set it.
- R10: A packet whose end pulse carries `in_bad` frees its buffer. It never becomes readable and does not set bit 0.
- R11: Bit 3 (DMA mode) is read/write and takes `csr_wdata[3]` on every register write.
- R12: `rx_irq` = overflow OR (`rx_int_en` AND packet-complete AND (NOT DMA mode OR unread bytes < 32)).
- R13: A read strobe on the last byte of the current packet, or on a zero-length current packet, frees its buffer, and the next packet becomes current. A read strobe with no complete packet has no effect. Start, byte and end strobes come in separate cycles. Bytes past 256 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_start | input | 1 | Start of an OUT packet |
| in_byte_vld | input | 1 | `in_byte` carries a packet byte |
| in_byte | input | 8 | Packet data byte |
| in_end | input | 1 | End of the packet |
| in_bad | input | 1 | With `in_end`: the packet failed its checks |
| rd_en | input | 1 | CPU pops the byte on `rd_data` |
| rd_data | output | 8 | Current byte of the oldest complete packet |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 32 | Control/status word |
| rx_int_en | input | 1 | Receive interrupt mask for the packet-complete event |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The bench fills both buffers and then offers a third packet. A controller that checked only the buffer being filled would overwrite a stored packet instead of raising overflow. A zero-length packet is sent and released with a single read strobe; a design that waited for a byte would hold the service bit high forever. A clearing write is placed in the same cycle as an end pulse, where a clear-wins design would lose the packet-complete event. In DMA mode the unread count is walked across 32 while the interrupt is watched, and an off-by-one compare would move the interrupt by one read. Long mixed traffic with concurrent reads, bad packets and random register writes then runs against the queue model.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  typedef enum logic [1:0] {
    BUF_FREE = 2'd0,
    BUF_FILL = 2'd1,
    BUF_FULL = 2'd2
  } buf_state_e;

  // Status word bit positions (software decodes these)
  localparam int CSR_SVC    = 0;
  localparam int CSR_PKT    = 1;
  localparam int CSR_OVF    = 2;
  localparam int CSR_DMA    = 3;
  localparam int CSR_NEMPTY = 6;
  localparam int CSR_SHORT  = 7;
endpackage

// File: rtl/iso_rx_bufmem.sv
module iso_rx_bufmem #(
  parameter int NBUF  = 2,
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] bank_q [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          bank_we;

    assign bank_we = wr_en && (wr_sel == SW'(b));

    always_ff @(posedge clk) begin
      if (bank_we) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign bank_q[b] = mem[rd_addr];
  end

  assign rd_data = bank_q[rd_sel];
endmodule

// File: rtl/iso_rx_csr.sv
module iso_rx_csr
  import iso_rx_pkg::*;
#(
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    wbits,      // [0] clear pkt, [1] clear ovf, [2] dma mode
  input  logic          pkt_set,
  input  logic          ovf_set,
  input  logic          svc,
  input  logic          nempty,
  input  logic          short_pkt,
  input  logic          below_lvl,
  input  logic          int_en,
  output logic [RW-1:0] rdata,
  output logic          irq
);
  logic pkt_q, pkt_d;
  logic ovf_q, ovf_d;
  logic dma_q, dma_d;

  always_comb begin
    pkt_d = pkt_set | (pkt_q & ~(we & wbits[0]));
    ovf_d = ovf_set | (ovf_q & ~(we & wbits[1]));
    dma_d = we ? wbits[2] : dma_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q <= 1'b0;
      ovf_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      pkt_q <= pkt_d;
      ovf_q <= ovf_d;
      dma_q <= dma_d;
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[CSR_SVC]    = svc;
    rdata[CSR_PKT]    = pkt_q;
    rdata[CSR_OVF]    = ovf_q;
    rdata[CSR_DMA]    = dma_q;
    rdata[CSR_NEMPTY] = nempty;
    rdata[CSR_SHORT]  = short_pkt;
  end

  assign irq = ovf_q | (int_en & pkt_q & (~dma_q | below_lvl));
endmodule

// File: rtl/iso_out_rx.sv
module iso_out_rx
  import iso_rx_pkg::*;
#(
  parameter int MAX_PKT   = 256,
  parameter int DMA_LEVEL = 32,
  parameter int DW        = 8,
  parameter int RW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_start,
  input  logic          in_byte_vld,
  input  logic [DW-1:0] in_byte,
  input  logic          in_end,
  input  logic          in_bad,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          csr_we,
  input  logic [7:0]    csr_wdata,
  output logic [RW-1:0] csr_rdata,
  input  logic          rx_int_en,
  output logic          rx_irq
);
  localparam int NBUF = 2;
  localparam int AW   = $clog2(MAX_PKT);
  localparam int LW   = $clog2(MAX_PKT + 1);
  localparam int HW   = LW + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // buffer ring state
  buf_state_e    st_q  [NBUF];
  buf_state_e    st_d  [NBUF];
  logic [LW-1:0] len_q [NBUF];
  logic [LW-1:0] len_d [NBUF];
  logic          wr_sel_q, wr_sel_d;
  logic          rd_sel_q, rd_sel_d;
  logic          fill_q,   fill_d;
  logic          drop_q,   drop_d;
  logic [LW-1:0] fidx_q,   fidx_d;
  logic [LW-1:0] ridx_q,   ridx_d;

  logic          mem_we;
  logic [DW-1:0] mem_q;
  logic          pkt_set, ovf_set;
  logic          cur_full, oth_full, oth_sel;
  logic [LW-1:0] cur_len;
  logic [HW-1:0] held;

  assign oth_sel  = ~rd_sel_q;
  assign cur_full = (st_q[rd_sel_q] == BUF_FULL);
  assign oth_full = (st_q[oth_sel]  == BUF_FULL);
  assign cur_len  = len_q[rd_sel_q];

  always_comb begin
    for (int b = 0; b < NBUF; b++) begin
      st_d[b]  = st_q[b];
      len_d[b] = len_q[b];
    end
    wr_sel_d = wr_sel_q;
    rd_sel_d = rd_sel_q;
    fill_d   = fill_q;
    drop_d   = drop_q;
    fidx_d   = fidx_q;
    ridx_d   = ridx_q;
    pkt_set  = 1'b0;
    ovf_set  = 1'b0;
    mem_we   = in_byte_vld && fill_q && (fidx_q < LW'(MAX_PKT));

    if (mem_we) begin
      fidx_d = fidx_q + 1'b1;
    end

    if (in_start && !fill_q && !drop_q) begin
      if (st_q[wr_sel_q] == BUF_FREE) begin
        st_d[wr_sel_q] = BUF_FILL;
        fill_d         = 1'b1;
        fidx_d         = '0;
      end else begin
        drop_d  = 1'b1;
        ovf_set = 1'b1;
      end
    end

    if (in_end && fill_q) begin
      fill_d  = 1'b0;
      pkt_set = 1'b1;
      if (in_bad) begin
        st_d[wr_sel_q] = BUF_FREE;
      end else begin
        st_d[wr_sel_q]  = BUF_FULL;
        len_d[wr_sel_q] = fidx_q;
        wr_sel_d        = ~wr_sel_q;
      end
    end

    if (in_end && drop_q) begin
      drop_d = 1'b0;
    end

    if (rd_en && cur_full) begin
      if ((cur_len == '0) || (ridx_q == cur_len - 1'b1)) begin
        st_d[rd_sel_q] = BUF_FREE;
        ridx_d         = '0;
        rd_sel_d       = ~rd_sel_q;
      end else begin
        ridx_d = ridx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int b = 0; b < NBUF; b++) begin
        st_q[b]  <= BUF_FREE;
        len_q[b] <= '0;
      end
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      fill_q   <= 1'b0;
      drop_q   <= 1'b0;
      fidx_q   <= '0;
      ridx_q   <= '0;
    end else begin
      for (int b = 0; b < NBUF; b++) begin
        st_q[b]  <= st_d[b];
        len_q[b] <= len_d[b];
      end
      wr_sel_q <= wr_sel_d;
      rd_sel_q <= rd_sel_d;
      fill_q   <= fill_d;
      drop_q   <= drop_d;
      fidx_q   <= fidx_d;
      ridx_q   <= ridx_d;
    end
  end

  iso_rx_bufmem #(
    .NBUF  (NBUF),
    .DEPTH (MAX_PKT),
    .DW    (DW)
  ) u_mem (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_sel  (wr_sel_q),
    .wr_addr (fidx_q[AW-1:0]),
    .wr_data (in_byte),
    .rd_sel  (rd_sel_q),
    .rd_addr (ridx_q[AW-1:0]),
    .rd_data (mem_q)
  );

  // unread bytes: only the current packet can be partly read
  always_comb begin
    held = '0;
    if (cur_full) held = held + HW'(cur_len - ridx_q);
    if (oth_full) held = held + HW'(len_q[oth_sel]);
  end

  assign rd_data = (cur_full && (cur_len != '0)) ? mem_q : '0;

  iso_rx_csr #(
    .RW (RW)
  ) u_csr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we        (csr_we),
    .wbits     (csr_wdata[3:1]),
    .pkt_set   (pkt_set),
    .ovf_set   (ovf_set),
    .svc       (cur_full | oth_full),
    .nempty    (held != '0),
    .short_pkt (cur_full && (cur_len < LW'(MAX_PKT))),
    .below_lvl (held < HW'(DMA_LEVEL)),
    .int_en    (rx_int_en),
    .rdata     (csr_rdata),
    .irq       (rx_irq)
  );
endmodule

// File: rtl/iso_out_rx_chk.sv
module iso_out_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_end,
  input logic        csr_we,
  input logic [7:0]  csr_wdata,
  input logic [31:0] csr_rdata,
  input logic [7:0]  rd_data,
  input logic        rx_int_en,
  input logic        rx_irq
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31:8] == 24'd0) && (csr_rdata[5:4] == 2'd0));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[2] && !(csr_we && csr_wdata[2])) |=> csr_rdata[2]);

  // R8
  pkt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_wdata[1] && !in_end) |=> !csr_rdata[1]);

  // R5
  nempty_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[6] |-> csr_rdata[0]);

  // R3
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rdata[6] |-> (rd_data == 8'd0));

  // R12
  ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[2] |-> rx_irq);

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !csr_rdata[2]) |-> (rx_int_en && csr_rdata[1]));
endmodule

bind iso_out_rx iso_out_rx_chk u_chk (.*);

// File: tb/tb_iso_out_rx.sv
module tb_iso_out_rx;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP       = 256;
  localparam int LVL        = 32;
  localparam int WDOG       = 150000;

  logic        clk, rst_n;
  logic        in_start, in_byte_vld, in_end, in_bad, rd_en, csr_we, rx_int_en;
  logic [7:0]  in_byte, csr_wdata, rd_data;
  logic [31:0] csr_rdata;
  logic        rx_irq;

  iso_out_rx dut (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_byte_vld(in_byte_vld),
    .in_byte(in_byte), .in_end(in_end), .in_bad(in_bad), .rd_en(rd_en),
    .rd_data(rd_data), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .rx_int_en(rx_int_en), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int data_q[$];   // unread bytes of complete packets, in order
  int olen_q[$];   // length of each complete packet
  int rem_q[$];    // bytes left in each complete packet
  int cur_q[$];    // packet being received
  bit m_fill, m_drop, m_pkt, m_ovf, m_dma;
  int pre_n;
  bit pre_fill, pre_drop, pset, oset;

  always @(posedge clk) begin
    if (!rst_n) begin
      data_q.delete(); olen_q.delete(); rem_q.delete(); cur_q.delete();
      m_fill = 0; m_drop = 0; m_pkt = 0; m_ovf = 0; m_dma = 0;
    end else begin
      pre_n = olen_q.size(); pre_fill = m_fill; pre_drop = m_drop;
      pset = 0; oset = 0;
      if (rd_en && pre_n > 0) begin
        if (rem_q[0] == 0) begin
          void'(olen_q.pop_front()); void'(rem_q.pop_front());
        end else begin
          void'(data_q.pop_front());
          rem_q[0] = rem_q[0] - 1;
          if (rem_q[0] == 0) begin
            void'(olen_q.pop_front()); void'(rem_q.pop_front());
          end
        end
      end
      if (in_start && !pre_fill && !pre_drop) begin
        if (pre_n < 2) begin m_fill = 1; cur_q.delete(); end
        else begin m_drop = 1; oset = 1; end
      end
      if (in_byte_vld && pre_fill && cur_q.size() < MAXP) cur_q.push_back(int'(in_byte));
      if (in_end && pre_fill) begin
        m_fill = 0; pset = 1;
        if (!in_bad) begin
          foreach (cur_q[i]) data_q.push_back(cur_q[i]);
          olen_q.push_back(cur_q.size());
          rem_q.push_back(cur_q.size());
        end
      end
      if (in_end && pre_drop) m_drop = 0;
      m_pkt = pset | (m_pkt & !(csr_we & csr_wdata[1]));
      m_ovf = oset | (m_ovf & !(csr_we & csr_wdata[2]));
      if (csr_we) m_dma = csr_wdata[3];
    end
  end

  // compare every cycle, after the edge has settled
  always @(posedge clk) begin
    if (cmp_on && !done) begin
      #1;
      chk("R4 service bit",   csr_rdata[0], olen_q.size() > 0);
      chk("R9 packet bit",    csr_rdata[1], m_pkt);
      chk("R7 overflow bit",  csr_rdata[2], m_ovf);
      chk("R11 dma bit",      csr_rdata[3], m_dma);
      chk("R5 not-empty bit", csr_rdata[6], data_q.size() > 0);
      chk("R6 short bit",     csr_rdata[7], (olen_q.size() > 0) && (olen_q[0] < MAXP));
      chk("R2 reserved bits", int'(csr_rdata[31:8]) | int'(csr_rdata[5:4]), 0);
      chk("R12 irq", rx_irq,
          m_ovf | (rx_int_en & m_pkt & (!m_dma | (data_q.size() < LVL))));
      chk("R3 read data", rd_data,
          ((olen_q.size() > 0) && (rem_q[0] > 0)) ? data_q[0] : 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic cyc(bit st, bit bv, logic [7:0] b, bit en, bit bad,
                     bit rd, bit we, logic [7:0] wd);
    @(negedge clk);
    in_start = st; in_byte_vld = bv; in_byte = b; in_end = en; in_bad = bad;
    rd_en = rd; csr_we = we; csr_wdata = wd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic rd_n(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 0, 1, 0, 8'h00);
  endtask

  task automatic wr(logic [7:0] v);
    cyc(0, 0, 8'h00, 0, 0, 0, 1, v);
  endtask

  task automatic send_pkt(int n, bit bad, bit rd_mix, bit we_end, logic [7:0] wd_end);
    step_lf();
    cyc(1, 0, 8'h00, 0, 0, rd_mix & lf[0], 0, 8'h00);
    for (int i = 0; i < n; i++) begin
      step_lf();
      cyc(0, 1, lf[7:0], 0, 0, rd_mix & lf[9], 0, 8'h00);
    end
    cyc(0, 0, 8'h00, 1, bad, 0, we_end, wd_end);
  endtask

  initial begin
    rst_n = 0; rx_int_en = 0;
    in_start = 0; in_byte_vld = 0; in_byte = 0; in_end = 0; in_bad = 0;
    rd_en = 0; csr_we = 0; csr_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
    chk("R1 reset status", int'(csr_rdata), 0);
    chk("R1 reset irq", rx_irq, 0);
    chk("R1 reset data", rd_data, 0);

    wr(8'h00); idle(1);
    chk("R8 zero write no effect", int'(csr_rdata), 0);
    rd_n(1); idle(1);
    chk("R13 read while empty", int'(csr_rdata), 0);

    send_pkt(5, 0, 0, 0, 8'h00); idle(1);
    chk("R3 service after short packet", csr_rdata[0], 1);
    chk("R6 short packet flagged", csr_rdata[7], 1);
    chk("R9 packet-complete set", csr_rdata[1], 1);

    send_pkt(MAXP, 0, 0, 0, 8'h00); idle(1);
    send_pkt(10, 0, 0, 0, 8'h00); idle(1);
    chk("R7 overflow on third packet", csr_rdata[2], 1);
    chk("R12 overflow drives irq", rx_irq, 1);

    wr(8'h06); idle(1);
    chk("R8 clear ovf and pkt", int'(csr_rdata[2:1]), 0);

    rd_n(5); idle(1);
    chk("R13 full packet now current", csr_rdata[7], 0);
    rd_n(MAXP - 1); idle(1);
    chk("R4 service held to last byte", csr_rdata[0], 1);
    rd_n(1); idle(1);
    chk("R4 service falls when drained", csr_rdata[0], 0);
    chk("R5 not-empty falls when drained", csr_rdata[6], 0);

    send_pkt(20, 1, 0, 0, 8'h00); idle(1);
    chk("R10 bad packet not held", csr_rdata[0], 0);
    chk("R10 bad packet sets complete", csr_rdata[1], 1);

    send_pkt(0, 0, 0, 0, 8'h00); idle(1);
    chk("R4 zero-length packet held", csr_rdata[0], 1);
    chk("R5 zero-length has no bytes", csr_rdata[6], 0);
    rd_n(1); idle(1);
    chk("R13 zero-length released by read", csr_rdata[0], 0);

    wr(8'h0A); rx_int_en = 1;
    send_pkt(40, 0, 0, 0, 8'h00); idle(1);
    chk("R11 dma bit written", csr_rdata[3], 1);
    chk("R12 dma irq held at 40 bytes", rx_irq, 0);
    rd_n(8); idle(1);
    chk("R12 dma irq held at 32 bytes", rx_irq, 0);
    rd_n(1); idle(1);
    chk("R12 dma irq at 31 bytes", rx_irq, 1);
    wr(8'h0A); idle(1);
    chk("R12 irq drops after clear", rx_irq, 0);
    rd_n(31); wr(8'h00); rx_int_en = 0;

    send_pkt(3, 0, 0, 1, 8'h02); idle(1);
    chk("R8 set wins over clear", csr_rdata[1], 1);
    rd_n(3);

    for (int k = 0; k < 40; k++) begin
      step_lf();
      send_pkt((lf[3:0] == 4'd0) ? MAXP : int'(lf[11:6]), lf[14:12] == 3'd0, 1, 0, 8'h00);
      step_lf();
      if (lf[5]) wr({4'h0, lf[8], lf[11:10], 1'b0});
      rx_int_en = lf[7];
      for (int j = 0; j < int'(lf[4:2]); j++) begin
        step_lf();
        cyc(0, 0, 8'h00, 0, 0, lf[0], 0, 8'h00);
      end
    end
    rd_n(700); idle(2);
    chk("R4 drained after traffic", csr_rdata[0], 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion (R13)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule